// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in several operating modes. A 5-bit mode code selects one of eight register banks. Some register indices have private copies per bank: the fast-interrupt bank and the dummy bank each own registers 8 to 14. The interrupt, supervisor, abort, undefined and system banks each own registers 13 and 14. Every other index is shared with the user bank. Instruction-side logic uses two combinational read ports and one write port, all of which see the registers of the current mode. A debug port reads or writes any register as it appears from any named mode.

A mode-change request gives the new mode code and takes effect on one clock edge. The bank state machine holds the current bank as its state: BK_USER, BK_FAST, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS and BK_DUMMY. A request that moves to a different bank is a swap transition, which changes the copies the ports see. A request whose code resolves to the current bank is a stay transition, which changes the stored mode code and nothing else. Leaving BK_DUMMY is a purge transition, which clears the dummy bank's private copies. With no request the state holds.

The block also holds a current status register and one saved status register for each of the fast-interrupt, interrupt, supervisor, abort and undefined banks. Byte enables control which fields are written. An output for the memory system tells it whether the present mode is privileged.

Top module: `bankreg_file`

## Requirements
- R1: Mode code to bank: 0 and 16 give user, 1 and 17 fast-interrupt, 2 and 18 interrupt, 3 and 19 supervisor, 23 abort, 27 undefined, 31 system; every other code gives the dummy bank.
- R2: In the fast-interrupt bank, registers 8..14 are private copies; writing them leaves the user bank's 8..14 unchanged, and the reverse also holds.
- R3: Registers 0..7 and 15 are shared by all banks. Registers 8..12 are shared by the user, interrupt, supervisor, abort, undefined and system banks. Those five non-user banks each have private 13 and 14.
- R4: A request with mode_chg=1 sets cur_mode to mode_new at the next edge. A register write in the same cycle lands in the new mode's view.
- R5: A request whose code maps to the bank already in use (for example 0 to 16) leaves every register value seen at every port unchanged.
- R6: When the dummy bank is left, its private registers 8..14 become zero, so a later read of them from the dummy view returns 0.
- R7: A debug access whose dbg_mode maps to the current bank uses the live registers. Any other dbg_mode reads or writes that mode's own copy, which the read and write ports see after a switch into that mode.
- R8: A saved-status read for a mode whose bank has no saved status register (user, system, dummy) returns the current status register. A saved-status write to such a mode changes nothing.
- R9: Each saved status register is written per byte: ssr_be[k] enables bits [8k+7:8k].
- R10: Current-status writes use the mode after any same-cycle change. In a user-bank mode only the flags byte [31:24] (sr_be[3]) is written. In any other mode, sr_be[3..0] enable flags [31:24], status [23:16], extension [15:8] and control [7:0].
- R11: priv_access is 0 when cur_mode[1:0] is 00 and 1 otherwise.
- R12: After reset cur_mode is 5'b10011 (supervisor), and all general, current-status and saved-status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data, current mode view |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data, current mode view |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register index |
| wr_data | input | 32 | Write port data |
| mode_chg | input | 1 | Mode-change request |
| mode_new | input | 5 | Requested mode code |
| cur_mode | output | 5 | Current mode code |
| priv_access | output | 1 | Privileged-access indication |
| dbg_mode | input | 5 | Mode whose view the debug port uses |
| dbg_idx | input | 4 | Debug register index |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |
| sr_we | input | 1 | Current status write enable |
| sr_be | input | 4 | Current status byte enables |
| sr_wdata | input | 32 | Current status write data |
| sr_rdata | output | 32 | Current status value |
| ssr_mode | input | 5 | Mode selecting a saved status register |
| ssr_we | input | 1 | Saved status write enable |
| ssr_be | input | 4 | Saved status byte enables |
| ssr_wdata | input | 32 | Saved status write data |
| ssr_rdata | output | 32 | Saved status read data |

## Verification
The hardest situation to reach is the round trip through the dummy bank. The bench first loads dummy registers 8..14 while in a dummy code, moves to a user code, and then must see zeros both through the debug port and after re-entering a different dummy code. It must also see that the user copies of 8..12 survived the trip. The stimulus walks all 32 mode codes in order and then repeats directed round trips in and out of the fast-interrupt and dummy banks. It places mode changes, port writes and debug writes on the same edge, and a behavioural swap-based model checks every visible value after each edge.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int REG_COUNT  = 16;
    localparam int IDX_W      = $clog2(REG_COUNT);
    localparam int MODE_W     = 5;
    localparam int HI_FIRST   = 8;
    localparam int HI_LAST    = 14;
    localparam int HI_COUNT   = HI_LAST - HI_FIRST + 1;
    localparam int PAIR_FIRST = 13;
    localparam int PAIR_BANKS = 5;
    localparam int FAST_BASE  = REG_COUNT;
    localparam int PAIR_BASE  = FAST_BASE + HI_COUNT;
    localparam int DUMMY_BASE = PAIR_BASE + 2 * PAIR_BANKS;
    localparam int SLOT_COUNT = DUMMY_BASE + HI_COUNT;
    localparam int SLOT_W     = $clog2(SLOT_COUNT);
    localparam int SAVED_COUNT = 5;

    typedef enum logic [2:0] {
        BK_USER  = 3'd0,
        BK_FAST  = 3'd1,
        BK_IRQ   = 3'd2,
        BK_SVC   = 3'd3,
        BK_ABT   = 3'd4,
        BK_UND   = 3'd5,
        BK_SYS   = 3'd6,
        BK_DUMMY = 3'd7
    } bank_e;

    function automatic bank_e mode_bank(input logic [MODE_W-1:0] m);
        bank_e b;
        case (m)
            5'd0, 5'd16: b = BK_USER;
            5'd1, 5'd17: b = BK_FAST;
            5'd2, 5'd18: b = BK_IRQ;
            5'd3, 5'd19: b = BK_SVC;
            5'd23:       b = BK_ABT;
            5'd27:       b = BK_UND;
            5'd31:       b = BK_SYS;
            default:     b = BK_DUMMY;
        endcase
        return b;
    endfunction

    function automatic logic owns_high(input bank_e b);
        return (b == BK_FAST) || (b == BK_DUMMY);
    endfunction

    function automatic logic has_saved(input bank_e b);
        return (b != BK_USER) && (b != BK_SYS) && (b != BK_DUMMY);
    endfunction

    // Physical slot: 0..15 user set, then fast 8..14, then five pairs, then dummy 8..14
    function automatic logic [SLOT_W-1:0] phys_slot(input bank_e b, input logic [IDX_W-1:0] r);
        int ri;
        int s;
        ri = int'(r);
        s  = ri;
        if (owns_high(b) && ri >= HI_FIRST && ri <= HI_LAST) begin
            s = ((b == BK_FAST) ? FAST_BASE : DUMMY_BASE) + (ri - HI_FIRST);
        end else if (b != BK_USER && !owns_high(b) && ri >= PAIR_FIRST && ri <= HI_LAST) begin
            s = PAIR_BASE + 2 * (int'(b) - int'(BK_IRQ)) + (ri - PAIR_FIRST);
        end
        return SLOT_W'(s);
    endfunction

endpackage

// File: rtl/bank_fsm.sv
module bank_fsm
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_chg,
    input  logic [MODE_W-1:0] mode_new,
    output logic [MODE_W-1:0] cur_mode,
    output bank_e             cur_bank,
    output bank_e             eff_bank,
    output logic              leave_dummy,
    output logic              priv_access
);

    localparam logic [MODE_W-1:0] RESET_MODE = 5'b10011;

    bank_e             state_q, state_d;
    logic [MODE_W-1:0] mode_q, mode_d;

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        if (mode_chg) begin
            state_d = mode_bank(mode_new);
            mode_d  = mode_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_SVC;
            mode_q  <= RESET_MODE;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        cur_mode    = mode_q;
        cur_bank    = state_q;
        eff_bank    = state_d;
        priv_access = |mode_q[1:0];
        unique case (state_q)
            BK_DUMMY: leave_dummy = (state_d != BK_DUMMY);
            BK_USER, BK_FAST, BK_IRQ, BK_SVC,
            BK_ABT, BK_UND, BK_SYS: leave_dummy = 1'b0;
            default: leave_dummy = 1'b0;
        endcase
    end

    // R4: mode code follows the request on the next edge
    p_mode_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (cur_mode == $past(mode_new)));

    // R11: a request with low bits 00 yields an unprivileged indication
    p_unpriv_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && mode_new[1:0] == 2'b00) |=> !priv_access);

endmodule

// File: rtl/reg_store.sv
module reg_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             cur_bank,
    input  bank_e             eff_bank,
    input  bank_e             dbg_bank,
    input  logic              leave_dummy,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  dbg_idx,
    input  logic              dbg_we,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] dbg_rdata
);

    localparam int RPORTS = 3;

    logic [DATA_W-1:0] slot_q [SLOT_COUNT];
    logic [SLOT_W-1:0] wr_slot, dbg_slot;
    logic [IDX_W-1:0]  rp_idx  [RPORTS];
    bank_e             rp_bank [RPORTS];
    logic [DATA_W-1:0] rp_data [RPORTS];

    assign wr_slot  = phys_slot(eff_bank, wr_idx);
    assign dbg_slot = phys_slot(dbg_bank, dbg_idx);

    assign rp_idx[0]  = rd_a_idx;
    assign rp_bank[0] = cur_bank;
    assign rp_idx[1]  = rd_b_idx;
    assign rp_bank[1] = cur_bank;
    assign rp_idx[2]  = dbg_idx;
    assign rp_bank[2] = dbg_bank;

    for (genvar g = 0; g < RPORTS; g++) begin : g_rport
        assign rp_data[g] = slot_q[phys_slot(rp_bank[g], rp_idx[g])];
    end

    assign rd_a_data = rp_data[0];
    assign rd_b_data = rp_data[1];
    assign dbg_rdata = rp_data[2];

    // Order inside the edge: purge, then port write, then debug write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SLOT_COUNT; k++) slot_q[k] <= '0;
        end else begin
            if (leave_dummy) begin
                for (int k = 0; k < HI_COUNT; k++) slot_q[DUMMY_BASE + k] <= '0;
            end
            if (wr_en)  slot_q[wr_slot]  <= wr_data;
            if (dbg_we) slot_q[dbg_slot] <= dbg_wdata;
        end
    end

    // R6: purge on leaving the dummy bank
    p_dummy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (leave_dummy && !(dbg_we && dbg_bank == BK_DUMMY))
        |=> (slot_q[DUMMY_BASE] == '0 && slot_q[DUMMY_BASE + HI_COUNT - 1] == '0));

    // R3: low registers are one shared set
    p_low_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < 4'd8 && !dbg_we)
        |=> (slot_q[$past(wr_idx)] == $past(wr_data)));

    // R2: a fast-bank high write never touches the user copy
    p_fast_private_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && eff_bank == BK_FAST && wr_idx >= 4'd8 && wr_idx <= 4'd14 && !dbg_we)
        |=> (slot_q[$past(wr_idx)] == $past(slot_q[wr_idx])));

endmodule

// File: rtl/status_bank.sv
module status_bank
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             eff_bank,
    input  bank_e             ssr_bank,
    input  logic              sr_we,
    input  logic [DATA_W/8-1:0] sr_be,
    input  logic [DATA_W-1:0] sr_wdata,
    input  logic              ssr_we,
    input  logic [DATA_W/8-1:0] ssr_be,
    input  logic [DATA_W-1:0] ssr_wdata,
    output logic [DATA_W-1:0] sr_rdata,
    output logic [DATA_W-1:0] ssr_rdata
);

    localparam int LANES = DATA_W / 8;
    localparam logic [LANES-1:0] FLAG_ONLY = {1'b1, {(LANES-1){1'b0}}};

    logic [DATA_W-1:0]                    cur_q;
    logic [SAVED_COUNT-1:0][DATA_W-1:0]   saved_q;
    logic [LANES-1:0]                     sr_mask;
    logic [2:0]                           ssr_slot;
    logic                                 ssr_ok;
    logic                                 user_now;

    assign user_now = (eff_bank == BK_USER);
    assign sr_mask  = user_now ? (sr_be & FLAG_ONLY) : sr_be;
    assign ssr_ok   = has_saved(ssr_bank);
    assign ssr_slot = 3'(int'(ssr_bank) - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            saved_q <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (sr_we && sr_mask[l]) cur_q[l*8 +: 8] <= sr_wdata[l*8 +: 8];
                if (ssr_we && ssr_ok && ssr_be[l])
                    saved_q[ssr_slot][l*8 +: 8] <= ssr_wdata[l*8 +: 8];
            end
        end
    end

    assign sr_rdata  = cur_q;
    assign ssr_rdata = ssr_ok ? saved_q[ssr_slot] : cur_q;

    // R10: a user-mode status write changes nothing below the flags byte
    p_user_flags_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_we && user_now) |=> (cur_q[DATA_W-9:0] == $past(cur_q[DATA_W-9:0])));

    // R8: a saved-status write to a bank without one is dropped
    p_ssr_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ssr_we && !ssr_ok) |=> $stable(saved_q));

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_chg,
    input  logic [4:0]        mode_new,
    output logic [4:0]        cur_mode,
    output logic              priv_access,
    input  logic [4:0]        dbg_mode,
    input  logic [3:0]        dbg_idx,
    input  logic              dbg_we,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata,
    input  logic              sr_we,
    input  logic [DATA_W/8-1:0] sr_be,
    input  logic [DATA_W-1:0] sr_wdata,
    output logic [DATA_W-1:0] sr_rdata,
    input  logic [4:0]        ssr_mode,
    input  logic              ssr_we,
    input  logic [DATA_W/8-1:0] ssr_be,
    input  logic [DATA_W-1:0] ssr_wdata,
    output logic [DATA_W-1:0] ssr_rdata
);

    bank_e cur_bank, eff_bank, dbg_bank, ssr_bank;
    logic  leave_dummy;

    assign dbg_bank = mode_bank(dbg_mode);
    assign ssr_bank = mode_bank(ssr_mode);

    bank_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_chg    (mode_chg),
        .mode_new    (mode_new),
        .cur_mode    (cur_mode),
        .cur_bank    (cur_bank),
        .eff_bank    (eff_bank),
        .leave_dummy (leave_dummy),
        .priv_access (priv_access)
    );

    reg_store #(.DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_bank    (cur_bank),
        .eff_bank    (eff_bank),
        .dbg_bank    (dbg_bank),
        .leave_dummy (leave_dummy),
        .rd_a_idx    (rd_a_idx),
        .rd_b_idx    (rd_b_idx),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .dbg_idx     (dbg_idx),
        .dbg_we      (dbg_we),
        .dbg_wdata   (dbg_wdata),
        .rd_a_data   (rd_a_data),
        .rd_b_data   (rd_b_data),
        .dbg_rdata   (dbg_rdata)
    );

    status_bank #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .eff_bank  (eff_bank),
        .ssr_bank  (ssr_bank),
        .sr_we     (sr_we),
        .sr_be     (sr_be),
        .sr_wdata  (sr_wdata),
        .ssr_we    (ssr_we),
        .ssr_be    (ssr_be),
        .ssr_wdata (ssr_wdata),
        .sr_rdata  (sr_rdata),
        .ssr_rdata (ssr_rdata)
    );

endmodule

// File: tb/bankreg_file_tb_top.sv
module bankreg_file_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, dbg_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, dbg_wdata, dbg_rdata;
    logic [31:0] sr_wdata, sr_rdata, ssr_wdata, ssr_rdata;
    logic        wr_en, mode_chg, priv_access, dbg_we, sr_we, ssr_we;
    logic [4:0]  mode_new, cur_mode, dbg_mode, ssr_mode;
    logic [3:0]  sr_be, ssr_be;

    bankreg_file dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string req = "R12";

    // Behavioural model: live registers plus saved copies, swapped on bank change
    logic [31:0] live [16];
    logic [31:0] cp [8][16];
    logic [31:0] m_sr;
    logic [31:0] m_ssr [8];
    logic [4:0]  m_mode;

    function automatic int bnk(input logic [4:0] m);
        if (m[3:0] == 4'd0) return 0;
        if (m[3:0] == 4'd1) return 1;
        if (m[3:0] == 4'd2) return 2;
        if (m[3:0] == 4'd3) return 3;
        if (m == 5'd23) return 4;
        if (m == 5'd27) return 5;
        if (m == 5'd31) return 6;
        return 7;
    endfunction

    function automatic bit hi8(input int b);
        return b == 1 || b == 7;
    endfunction

    function automatic bit saved_ok(input int b);
        return b >= 1 && b <= 5;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int l = 0; l < 4; l++) if (be[l]) r[l*8 +: 8] = n[l*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] dread(input logic [4:0] m, input int r);
        int b = bnk(m);
        int cb = bnk(m_mode);
        if (b == cb || r < 8 || r == 15) return live[r];
        if (hi8(b) || r >= 13) return cp[b][r];
        if (hi8(cb)) return cp[0][r];
        return live[r];
    endfunction

    task automatic dwrite(input logic [4:0] m, input int r, input logic [31:0] v);
        int b = bnk(m);
        int cb = bnk(m_mode);
        if (b == cb || r < 8 || r == 15) live[r] = v;
        else if (hi8(b) || r >= 13) cp[b][r] = v;
        else if (hi8(cb)) cp[0][r] = v;
        else live[r] = v;
    endtask

    task automatic swap_to(input logic [4:0] nm);
        int ob = bnk(m_mode);
        int nb = bnk(nm);
        if (ob != nb) begin
            if (ob == 1) for (int r = 8; r <= 14; r++) cp[1][r] = live[r];
            else if (ob == 7) for (int r = 8; r <= 14; r++) cp[7][r] = '0;
            else begin
                if (hi8(nb)) for (int r = 8; r <= 12; r++) cp[0][r] = live[r];
                cp[ob][13] = live[13];
                cp[ob][14] = live[14];
            end
            if (hi8(nb)) for (int r = 8; r <= 14; r++) live[r] = cp[nb][r];
            else begin
                if (hi8(ob)) for (int r = 8; r <= 12; r++) live[r] = cp[0][r];
                live[13] = cp[nb][13];
                live[14] = cp[nb][14];
            end
        end
        m_mode = nm;
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        int sb;
        rd_a_idx = 4'($urandom % 16);
        rd_b_idx = 4'($urandom % 16);
        #1;
        chk("rd_a_data", rd_a_data, live[rd_a_idx]);
        chk("rd_b_data", rd_b_data, live[rd_b_idx]);
        chk("dbg_rdata", dbg_rdata, dread(dbg_mode, int'(dbg_idx)));
        chk("sr_rdata", sr_rdata, m_sr);
        sb = bnk(ssr_mode);
        chk("ssr_rdata", ssr_rdata, saved_ok(sb) ? m_ssr[sb] : m_sr);
        chk("cur_mode", 32'(cur_mode), 32'(m_mode));
        chk("priv_access R11", 32'(priv_access), 32'(m_mode[1:0] != 2'b00));
        @(posedge clk);
        if (mode_chg) swap_to(mode_new);
        if (sr_we) m_sr = merge(m_sr, sr_wdata, (bnk(m_mode) == 0) ? (sr_be & 4'b1000) : sr_be);
        sb = bnk(ssr_mode);
        if (ssr_we && saved_ok(sb)) m_ssr[sb] = merge(m_ssr[sb], ssr_wdata, ssr_be);
        if (wr_en) live[wr_idx] = wr_data;
        if (dbg_we) dwrite(dbg_mode, int'(dbg_idx), dbg_wdata);
        @(negedge clk);
        wr_en = 0; mode_chg = 0; dbg_we = 0; sr_we = 0; ssr_we = 0;
    endtask

    task automatic chg(input logic [4:0] m);
        mode_chg = 1; mode_new = m; step();
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        wr_en = 1; wr_idx = 4'(i); wr_data = d; step();
    endtask

    task automatic dbg(input logic [4:0] m, input int i);
        dbg_mode = m; dbg_idx = 4'(i); step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; mode_chg = 0; dbg_we = 0; sr_we = 0; ssr_we = 0;
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0; mode_new = 0;
        dbg_mode = 5'd19; dbg_idx = 0; dbg_wdata = 0;
        sr_be = 0; sr_wdata = 0; ssr_mode = 5'd19; ssr_be = 0; ssr_wdata = 0;
        for (int b = 0; b < 8; b++) begin
            m_ssr[b] = '0;
            for (int r = 0; r < 16; r++) cp[b][r] = '0;
        end
        for (int r = 0; r < 16; r++) live[r] = '0;
        m_sr = '0; m_mode = 5'b10011;
        repeat (3) @(negedge clk);
        rst_n = 1;

        req = "R12";
        for (int i = 0; i < 16; i++) dbg(5'd19, i);

        req = "R1";
        for (int m = 0; m < 32; m++) begin
            chg(5'(m));
            wr(13, 32'h1300_0000 + m);
            wr(9, 32'h0900_0000 + m);
            for (int k = 0; k < 32; k += 5) dbg(5'(k), 13);
        end

        req = "R2";
        chg(5'd16);
        for (int r = 8; r <= 14; r++) wr(r, 32'hAAAA_0000 + r);
        chg(5'd17);
        for (int r = 8; r <= 14; r++) wr(r, 32'hF00F_0000 + r);
        chg(5'd16);
        for (int r = 8; r <= 14; r++) dbg(5'd17, r);
        for (int r = 8; r <= 14; r++) dbg(5'd0, r);

        req = "R3";
        chg(5'd19);
        for (int r = 0; r < 16; r++) wr(r, 32'h5C00_0000 + r);
        chg(5'd18);
        for (int r = 0; r < 16; r++) dbg(5'd18, r);
        for (int r = 8; r <= 14; r++) dbg(5'd31, r);

        req = "R4";
        mode_chg = 1; mode_new = 5'd17; wr_en = 1; wr_idx = 4'd10; wr_data = 32'hC0DE_0010; step();
        mode_chg = 1; mode_new = 5'd23; wr_en = 1; wr_idx = 4'd14; wr_data = 32'hC0DE_0014; step();
        dbg(5'd17, 10); dbg(5'd23, 14); dbg(5'd16, 10);

        req = "R5";
        chg(5'd0);
        wr(13, 32'h5A5A_0013);
        chg(5'd16);
        for (int r = 0; r < 16; r++) dbg(5'd16, r);

        req = "R6";
        chg(5'd4);
        for (int r = 8; r <= 14; r++) wr(r, 32'hD0D0_0000 + r);
        chg(5'd16);
        for (int r = 8; r <= 14; r++) dbg(5'd4, r);
        chg(5'd9);
        for (int r = 8; r <= 14; r++) dbg(5'd9, r);
        chg(5'd0);

        req = "R7";
        for (int n = 0; n < 60; n++) begin
            dbg_we = 1; dbg_wdata = $urandom;
            dbg(5'($urandom % 32), int'($urandom % 16));
            dbg(dbg_mode, int'(dbg_idx));
        end

        req = "R9";
        for (int n = 0; n < 40; n++) begin
            ssr_we = 1; ssr_be = 4'($urandom); ssr_wdata = $urandom;
            ssr_mode = 5'($urandom % 32);
            step();
            step();
        end

        req = "R8";
        ssr_mode = 5'd16; ssr_we = 1; ssr_be = 4'hF; ssr_wdata = 32'hDEAD_BEEF; step();
        ssr_mode = 5'd31; ssr_we = 1; ssr_be = 4'hF; ssr_wdata = 32'hBAD0_0031; step();
        ssr_mode = 5'd5;  ssr_we = 1; ssr_be = 4'hF; ssr_wdata = 32'hBAD0_0005; step();
        for (int m = 0; m < 32; m++) begin ssr_mode = 5'(m); step(); end

        req = "R10";
        chg(5'd16);
        sr_we = 1; sr_be = 4'hF; sr_wdata = 32'h1234_5678; step();
        chg(5'd19);
        sr_we = 1; sr_be = 4'b0101; sr_wdata = 32'h9ABC_DEF0; step();
        sr_we = 1; sr_be = 4'b1010; sr_wdata = 32'h1357_9BDF; step();
        mode_chg = 1; mode_new = 5'd0; sr_we = 1; sr_be = 4'hF; sr_wdata = 32'h8642_0000; step();
        step();

        req = "R11";
        for (int m = 0; m < 32; m++) chg(5'(m));

        req = "R4";
        for (int n = 0; n < 400; n++) begin
            mode_chg = ($urandom % 4) == 0;
            mode_new = 5'($urandom % 32);
            wr_en = $urandom % 2; wr_idx = 4'($urandom % 16); wr_data = $urandom;
            dbg_we = ($urandom % 3) == 0; dbg_wdata = $urandom;
            dbg_mode = 5'($urandom % 32); dbg_idx = 4'($urandom % 16);
            sr_we = ($urandom % 4) == 0; sr_be = 4'($urandom); sr_wdata = $urandom;
            ssr_we = ($urandom % 4) == 0; ssr_be = 4'($urandom); ssr_wdata = $urandom;
            ssr_mode = 5'($urandom % 32);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule